// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. A start strobe loads a starting column and a mode word: a 3-bit length code and an ordering bit. From the next cycle the block presents one column per enabled clock, with a flag for each valid beat and a flag on the final beat of a fixed-length burst. Sequential ordering counts upward and wraps inside the block of columns that the burst length selects. Interleaved ordering XORs the beat index into the low address bits. A full-page burst walks every column of the 256-column row, wraps from 255 to 0, and keeps going until a stop request ends it.

The clock-enable input acts as a clock suspend. While it is low, the counter and outputs hold their values, and start and stop requests are not sampled. A start that arrives during a running burst restarts the sequence at the new column. A reserved length code runs as a single-beat burst and sets a sticky error flag, which only reset clears. Programming the mode and moving data are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: After synchronous active-low reset, `beat_valid`, `last_beat` and `cfg_err` are 0 and `col` is 0.
- R2: A `start` sampled with `cke` high makes `beat_valid` 1 on the next cycle, with `col` equal to the sampled `start_col` (beat 0).
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `last_beat` is 1 exactly on the final beat, and `beat_valid` is 0 on the cycle after it unless a new start arrives.
- R4: With `burst_type` 0 and a fixed length L, beat k keeps the upper bits of the start column. Its low log2(L) bits are (start + k) mod L.
- R5: With `burst_type` 1 and a fixed length L, beat k keeps the upper bits of the start column. Its low log2(L) bits are the start's low bits XOR k.
- R6: Length code 111 is full page. Beat k is (start + k) mod 256 whatever the ordering bit. The burst runs without end, and `last_beat` stays 0.
- R7: A `stop` sampled with `cke` high during a burst ends it, so `beat_valid` is 0 on the next cycle.
- R8: While `cke` is low, `col`, `beat_valid` and `last_beat` hold their values, and `start` and `stop` are ignored.
- R9: Length codes 100, 101 and 110 run as one-beat bursts and set `cfg_err`. `cfg_err` then stays 1 until reset.
- R10: A `start` during an active burst restarts at the new column with the new mode. When `start` and `stop` arrive together, `start` wins.
- R11: Length and ordering are captured at start. Changing `len_code` or `burst_type` during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the block |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | Starting column |
| len_code | input | 3 | Burst length code |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Terminate the running burst |
| col | output | 8 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Sticky flag: a reserved length code was used |

## Verification
The bench targets start columns that are not aligned and start columns at the top of their block (for example 0xFD and 0xFF). At those columns a design that adds without confining the carry would spill into the upper bits, and a design that mixes up the two orderings would put out the wrong columns. A full-page run crosses column 255. A design that wraps inside an 8-beat block, or that raises the last-beat flag, would show it there. Clock-enable low is held together with start and stop requests, which catches a counter that leaks a step or a request that leaks through the suspend. The remaining targets are a restart with stop pending, a mode change during a burst, and a reserved code followed by a valid burst. A design that gave stop priority, re-decoded the live mode inputs, or let the error flag clear would fail these.

// File: rtl/bcg_pkg.sv
// Package: shared widths, length-code values and the decoded mode record
// for the burst column address generator. Assumes codes are 3 bits.
package bcg_pkg;

    localparam int LEN_CODE_W = 3;

    // Length code values, compared by the mode decoder.
    localparam logic [LEN_CODE_W-1:0] LC_ONE  = 3'b000;
    localparam logic [LEN_CODE_W-1:0] LC_TWO  = 3'b001;
    localparam logic [LEN_CODE_W-1:0] LC_FOUR = 3'b010;
    localparam logic [LEN_CODE_W-1:0] LC_EIGHT = 3'b011;
    localparam logic [LEN_CODE_W-1:0] LC_PAGE = 3'b111;

    typedef enum logic {
        ORD_SEQ  = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

endpackage

// File: rtl/bcg_mode_decode.sv
// Module: bcg_mode_decode
// Turns a length code into a low-bit mask (burst length minus one), a
// full-page flag and a reserved-code flag. Purely combinational.
// Assumes COL_W >= 3 so an 8-beat mask fits.
module bcg_mode_decode #(
    parameter int COL_W = 8
) (
    input  logic [bcg_pkg::LEN_CODE_W-1:0] len_code,
    output logic [COL_W-1:0]               len_mask,
    output logic                           full_page,
    output logic                           reserved
);
    import bcg_pkg::*;

    // Map each code to the beat-index mask and flags.
    always_comb begin
        len_mask  = '0;
        full_page = 1'b0;
        reserved  = 1'b0;
        unique case (len_code)
            LC_ONE:   len_mask = '0;
            LC_TWO:   len_mask = COL_W'(1);
            LC_FOUR:  len_mask = COL_W'(3);
            LC_EIGHT: len_mask = COL_W'(7);
            LC_PAGE: begin
                len_mask  = '1;
                full_page = 1'b1;
            end
            default: begin
                len_mask = '0;
                reserved = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bcg_beat_counter.sv
// Module: bcg_beat_counter
// Holds the burst-active state and the beat index. Advances only on edges
// where cke is high. Start has priority over stop and over natural end.
// A fixed burst ends after the beat whose index equals the mask; a
// full-page burst only ends on stop. Assumes mask = length - 1.
module bcg_beat_counter #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             stop,
    input  logic             full_q,
    input  logic [COL_W-1:0] mask_q,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic             last
);
    logic at_end;

    // Final beat of a fixed-length burst.
    always_comb at_end = active && !full_q && (beat == mask_q);

    // Beat index and active flag, frozen while cke is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (cke) begin
            if (start) begin
                active <= 1'b1;
                beat   <= '0;
            end else if (active) begin
                if (stop || at_end) begin
                    active <= 1'b0;
                    beat   <= '0;
                end else begin
                    beat <= beat + COL_W'(1);
                end
            end
        end
    end

    // Last-beat indication to the outside.
    always_comb last = at_end;

endmodule

// File: rtl/bcg_addr_map.sv
// Module: bcg_addr_map
// Forms the column of the current beat from the captured start column,
// the beat index, the length mask and the ordering. Bits outside the mask
// come from the start column; bits inside come from either the sum
// (sequential) or the XOR (interleaved). Combinational.
module bcg_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  bcg_pkg::order_e  order,
    output logic [COL_W-1:0] col
);
    import bcg_pkg::*;

    logic [COL_W-1:0] seq_val;
    logic [COL_W-1:0] xor_val;
    logic [COL_W-1:0] inner;

    // Candidate low-bit values for both orderings.
    always_comb begin
        seq_val = base + beat;
        xor_val = base ^ beat;
        inner   = (order == ORD_XOR) ? xor_val : seq_val;
    end

    // Per-bit select between start column and ordered value.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? inner[i] : base[i];
    end

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Column address generator for one DRAM burst. Captures start column and
// decoded mode on a start sampled with cke high, then steps one beat per
// enabled clock. Full page ignores the ordering bit and runs until stop.
// Reserved length codes run one beat and set a sticky error.
// Assumes the caller holds cke low to suspend; all inputs synchronous.
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cke,
    input  logic                           start,
    input  logic [COL_W-1:0]               start_col,
    input  logic [bcg_pkg::LEN_CODE_W-1:0] len_code,
    input  logic                           burst_type,
    input  logic                           stop,
    output logic [COL_W-1:0]               col,
    output logic                           beat_valid,
    output logic                           last_beat,
    output logic                           cfg_err
);
    import bcg_pkg::*;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_rsv;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    order_e           order_q;
    logic             active;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] col_raw;
    logic             take;

    bcg_mode_decode #(.COL_W(COL_W)) i_dec (
        .len_code  (len_code),
        .len_mask  (dec_mask),
        .full_page (dec_full),
        .reserved  (dec_rsv)
    );

    // A start counts only on an enabled edge.
    always_comb take = cke && start;

    // Capture start column and decoded mode at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            order_q <= ORD_SEQ;
        end else if (take) begin
            base_q  <= start_col;
            mask_q  <= dec_mask;
            full_q  <= dec_full;
            order_q <= (burst_type && !dec_full) ? ORD_XOR : ORD_SEQ;
        end
    end

    // Sticky flag for reserved length codes, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (take && dec_rsv) begin
            cfg_err <= 1'b1;
        end
    end

    bcg_beat_counter #(.COL_W(COL_W)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .start  (start),
        .stop   (stop),
        .full_q (full_q),
        .mask_q (mask_q),
        .active (active),
        .beat   (beat),
        .last   (last_beat)
    );

    bcg_addr_map #(.COL_W(COL_W)) i_map (
        .base  (base_q),
        .beat  (beat),
        .mask  (mask_q),
        .order (order_q),
        .col   (col_raw)
    );

    // Output stage.
    always_comb begin
        col        = col_raw;
        beat_valid = active;
    end

endmodule

// File: rtl/burst_col_gen_chk.sv
// Module: burst_col_gen_chk
// Port-level protocol checks for burst_col_gen, attached by bind.
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col,
    input logic             beat_valid,
    input logic             last_beat,
    input logic             cfg_err
);
    // R2 and R10: an accepted start shows beat 0 at the new column.
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (beat_valid && col == $past(start_col)));

    // R3: after the last beat, the burst is over unless restarted.
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && last_beat && !start) |=> !beat_valid);

    // R3: the last-beat flag only appears on a valid beat.
    a_r3_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    // R7: stop ends the burst.
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && stop && !start) |=> !beat_valid);

    // R8: suspended clock holds all burst outputs.
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col) && $stable(beat_valid) && $stable(last_beat)));

    // R9: the error flag is sticky.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .start      (start),
    .stop       (stop),
    .start_col  (start_col),
    .col        (col),
    .beat_valid (beat_valid),
    .last_beat  (last_beat),
    .cfg_err    (cfg_err)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       burst_type = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col;
    logic       beat_valid;
    logic       last_beat;
    logic       cfg_err;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .len_code(len_code), .burst_type(burst_type),
        .stop(stop), .col(col), .beat_valid(beat_valid),
        .last_beat(last_beat), .cfg_err(cfg_err)
    );

    // Stimulus table: {len_code, burst_type, start_col}.
    localparam int NVEC = 10;
    localparam logic [11:0] VEC [NVEC] = '{
        {3'b000, 1'b0, 8'h37}, {3'b001, 1'b0, 8'h37}, {3'b001, 1'b1, 8'h37},
        {3'b010, 1'b0, 8'h3E}, {3'b010, 1'b1, 8'h3E}, {3'b011, 1'b0, 8'hFD},
        {3'b011, 1'b1, 8'hFD}, {3'b011, 1'b0, 8'h05}, {3'b010, 1'b1, 8'hFF},
        {3'b011, 1'b1, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: the edge, then back to the falling edge for sampling.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int burst_len(input logic [2:0] code);
        case (code)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            default: return 1;
        endcase
    endfunction

    // Expected column from R4/R5 for fixed lengths.
    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic t, input int k);
        logic [7:0] m;
        logic [7:0] lo;
        m  = 8'(burst_len(code) - 1);
        lo = t ? ((s ^ 8'(k)) & m) : ((s + 8'(k)) & m);
        return (s & ~m) | lo;
    endfunction

    task automatic begin_burst(input logic [2:0] code, input logic t, input logic [7:0] s);
        len_code = code; burst_type = t; start_col = s; start = 1'b1;
        step();
        start = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nerr++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check("R1 valid", beat_valid, 0);
        check("R1 last", last_beat, 0);
        check("R1 err", cfg_err, 0);
        check("R1 col", col, 0);
        step();
        check("R1 idle valid", beat_valid, 0);

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] code;
            logic       t;
            logic [7:0] s;
            int         n;
            {code, t, s} = VEC[i];
            n = burst_len(code);
            begin_burst(code, t, s);
            check("R2 start col", col, s);
            for (int k = 0; k < n; k++) begin
                check("R3 valid", beat_valid, 1);
                check(t ? "R5 col" : "R4 col", col, exp_col(s, code, t, k));
                check("R3 last", last_beat, (k == n - 1));
                step();
            end
            check("R3 end", beat_valid, 0);
        end

        // R6: full page across 255 -> 0, ordering bit ignored, no last flag
        begin_burst(3'b111, 1'b1, 8'hFC);
        for (int k = 0; k < 260; k++) begin
            check("R6 col", col, 8'(8'hFC + k));
            check("R6 last", last_beat, 0);
            check("R6 valid", beat_valid, 1);
            step();
        end
        // R7: stop ends full page
        stop = 1'b1; step(); stop = 1'b0;
        check("R7 page stop", beat_valid, 0);

        // R7: stop ends fixed burst early
        begin_burst(3'b011, 1'b0, 8'h10);
        step();
        check("R7 beat1", col, 8'h11);
        stop = 1'b1; step(); stop = 1'b0;
        check("R7 stop valid", beat_valid, 0);
        check("R7 stop last", last_beat, 0);

        // R8: cke low freezes and ignores start/stop
        begin_burst(3'b011, 1'b0, 8'h20);
        step();
        check("R8 pre", col, 8'h21);
        cke = 1'b0; start = 1'b1; start_col = 8'h99; stop = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R8 col held", col, 8'h21);
            check("R8 valid held", beat_valid, 1);
        end
        cke = 1'b1; start = 1'b0; stop = 1'b0;
        step();
        check("R8 resume", col, 8'h22);
        stop = 1'b1; step(); stop = 1'b0;

        // R11: mode change mid-burst ignored
        begin_burst(3'b010, 1'b0, 8'h41);
        len_code = 3'b011; burst_type = 1'b1;
        check("R11 b0", col, 8'h41); step();
        check("R11 b1", col, 8'h42); step();
        check("R11 b2", col, 8'h43); step();
        check("R11 b3", col, 8'h40);
        check("R11 last", last_beat, 1); step();
        check("R11 end", beat_valid, 0);

        // R10: restart with stop pending; start wins
        begin_burst(3'b011, 1'b0, 8'h50);
        step(); step();
        check("R10 pre", col, 8'h52);
        start = 1'b1; stop = 1'b1; start_col = 8'h0A; len_code = 3'b001; burst_type = 1'b0;
        step();
        start = 1'b0; stop = 1'b0;
        check("R10 restart col", col, 8'h0A);
        check("R10 restart valid", beat_valid, 1);
        step();
        check("R10 b1", col, 8'h0B);
        check("R10 last", last_beat, 1);
        step();
        check("R10 end", beat_valid, 0);

        // R9: reserved code runs one beat, sticky error
        check("R9 err clear", cfg_err, 0);
        begin_burst(3'b101, 1'b0, 8'h77);
        check("R9 col", col, 8'h77);
        check("R9 last", last_beat, 1);
        step();
        check("R9 end", beat_valid, 0);
        check("R9 err set", cfg_err, 1);
        begin_burst(3'b001, 1'b0, 8'h30);
        step(); step();
        check("R9 err sticky", cfg_err, 1);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R9 err reset", cfg_err, 0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule